// File: doc/BRIEF.md
# Line-Ready Load Gate

This block sits between a DMA write port and the load ports of a multi-lane accelerator datapath. It holds the local buffer and one ready bit for each fixed-size chunk of that buffer. Computation can begin while the buffer is still being filled. Each lane that loads from a chunk that has already arrived gets its data one cycle later. A lane that loads from a chunk still in flight is told to stall, and the other lanes keep going.

A start pulse marks every chunk empty before a new transfer. The DMA side writes one word per cycle and writes the words of a chunk in ascending order. A chunk becomes ready on the cycle after its highest-offset word is written. The chunk size is a parameter. Setting it to half the buffer gives two halves that fill and drain independently, which is double-buffering.

Top module: `ls_gate`

## Requirements
- R1: While reset is low and in the cycle after it, every chunk is empty and `ld_rvalid_o` is all zero.
- R2: A chunk's ready bit is set only by a fill write to the chunk's last word, offset CHUNK_WORDS-1. Writes to the chunk's other words leave loads to that chunk stalled.
- R3: A load to a ready chunk has `ld_stall_o` low in its cycle. In the next cycle `ld_rvalid_o` is high and `ld_rdata_o` holds the word stored at that address before the load's cycle.
- R4: A load to an empty chunk has `ld_stall_o` high in its cycle and produces no `ld_rvalid_o` in the next cycle. A lane with no valid load never stalls.
- R5: A load presented in the same cycle as the fill of its chunk's last word stalls in that cycle. If the load is held, it is accepted in the following cycle.
- R6: Each lane's stall depends only on its own address. One lane stalling never delays another lane whose chunk is ready.
- R7: `start_i` empties every chunk from the next cycle on. It takes precedence over a last-word fill in the same cycle, although that word's data is still stored.
- R8: The chunk of a word address is the address divided by CHUNK_WORDS, its upper address bits. With CHUNK_WORDS equal to half of DEPTH, the two halves become ready independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Marks all chunks empty |
| fill_valid_i | input | 1 | DMA word write strobe |
| fill_addr_i | input | AW | Word address of the DMA write |
| fill_data_i | input | W | DMA write data |
| ld_valid_i | input | LANES | Per-lane load request |
| ld_addr_i | input | LANES*AW | Per-lane word address, lane l at bits l*AW upward |
| ld_stall_o | output | LANES | Lane must hold its load, chunk not ready |
| ld_rvalid_o | output | LANES | Load data valid, one cycle after acceptance |
| ld_rdata_o | output | LANES*W | Per-lane load data |

## Verification
The hardest case is a load that lands in exactly the cycle in which the last word of its chunk is being written. The case gets harder when a start pulse coincides with that write. The bench holds one lane on a chunk while the DMA side walks through that chunk's words. This places the last-word write under a waiting load, and a later sequence fires start in the same cycle as a last-word write. A long random phase mixes sequential fills, sparse start pulses and two-lane loads. It is checked every clock against a behavioural model, and a second instance with two half-buffer chunks covers the double-buffering setting.

// File: rtl/ls_gate.sv
module ls_gate #(
  parameter int W           = 32,
  parameter int DEPTH       = 1024,
  parameter int CHUNK_WORDS = 8,
  parameter int LANES       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  fill_valid_i,
  input  logic [$clog2(DEPTH)-1:0] fill_addr_i,
  input  logic [W-1:0]          fill_data_i,
  input  logic [LANES-1:0]      ld_valid_i,
  input  logic [LANES*$clog2(DEPTH)-1:0] ld_addr_i,
  output logic [LANES-1:0]      ld_stall_o,
  output logic [LANES-1:0]      ld_rvalid_o,
  output logic [LANES*W-1:0]    ld_rdata_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int OW  = $clog2(CHUNK_WORDS);
  localparam int NCH = DEPTH / CHUNK_WORDS;

  logic [NCH-1:0] full_q;
  logic [W-1:0]   mem [DEPTH];

  wire fill_last = fill_valid_i && (fill_addr_i[OW-1:0] == OW'(CHUNK_WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n)         full_q <= '0;
    else if (start_i)   full_q <= '0;
    else if (fill_last) full_q[fill_addr_i[AW-1:OW]] <= 1'b1;
  end

  always_ff @(posedge clk)
    if (fill_valid_i) mem[fill_addr_i] <= fill_data_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire [AW-1:0] addr = ld_addr_i[l*AW +: AW];
    wire          hit  = full_q[addr[AW-1:OW]];
    logic [W-1:0] rdata_q;

    assign ld_stall_o[l] = ld_valid_i[l] & ~hit;

    always_ff @(posedge clk) begin
      if (!rst_n) ld_rvalid_o[l] <= 1'b0;
      else        ld_rvalid_o[l] <= ld_valid_i[l] & hit;
    end

    always_ff @(posedge clk)
      if (ld_valid_i[l] && hit) rdata_q <= mem[addr];

    assign ld_rdata_o[l*W +: W] = rdata_q;
  end
endmodule

// File: rtl/ls_gate_chk.sv
module ls_gate_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LANES-1:0] ld_valid_i,
  input logic [LANES-1:0] ld_stall_o,
  input logic [LANES-1:0] ld_rvalid_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (ld_rvalid_o == '0));

  // R7
  start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((ld_valid_i & ~ld_stall_o) == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4
    stall_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i[g] && ld_stall_o[g]) |=> !ld_rvalid_o[g]);
    // R3
    accept_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i[g] && !ld_stall_o[g]) |=> ld_rvalid_o[g]);
    // R4
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid_i[g] |-> !ld_stall_o[g]);
  end
endmodule

bind ls_gate ls_gate_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/ls_gate_tb_top.sv
module ls_gate_tb_top;
  localparam int W = 32, DEPTH = 1024, CH = 8, L = 2, AW = 10, NCH = DEPTH / CH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, fv = 1'b0;
  logic [AW-1:0] fa = '0;
  logic [W-1:0]  fd = '0;
  logic [L-1:0]  lv = '0;
  logic [L*AW-1:0] la = '0;
  logic [L-1:0]  lstall, lrv;
  logic [L*W-1:0] lrd;

  ls_gate #(.W(W), .DEPTH(DEPTH), .CHUNK_WORDS(CH), .LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fill_valid_i(fv), .fill_addr_i(fa),
    .fill_data_i(fd), .ld_valid_i(lv), .ld_addr_i(la), .ld_stall_o(lstall),
    .ld_rvalid_o(lrv), .ld_rdata_o(lrd));

  logic d_start = 1'b0, d_fv = 1'b0;
  logic [5:0] d_fa = '0, d_la = '0;
  logic [W-1:0] d_fd = '0, d_rd;
  logic d_lv = 1'b0, d_stall, d_rv;

  ls_gate #(.W(W), .DEPTH(64), .CHUNK_WORDS(32), .LANES(1)) dbl_i (
    .clk(clk), .rst_n(rst_n), .start_i(d_start), .fill_valid_i(d_fv), .fill_addr_i(d_fa),
    .fill_data_i(d_fd), .ld_valid_i(d_lv), .ld_addr_i(d_la), .ld_stall_o(d_stall),
    .ld_rvalid_o(d_rv), .ld_rdata_o(d_rd));

  int n_chk = 0, n_fail = 0;
  int ref_mem [DEPTH];
  bit ref_full [NCH];
  bit pend_v [L];
  int pend_d [L];

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(string tag);
    bit nv [L];
    int nd [L];
    #1;
    for (int l = 0; l < L; l++) begin
      int a = int'(la[l*AW +: AW]);
      bit es = lv[l] && !ref_full[a / CH];
      chk(lstall[l] == es, tag, $sformatf("lane%0d stall", l), lstall[l], es);
      chk(lrv[l] == pend_v[l], tag, $sformatf("lane%0d rvalid", l), lrv[l], pend_v[l]);
      if (pend_v[l] && lrv[l])
        chk(lrd[l*W +: W] == W'(pend_d[l]), tag, $sformatf("lane%0d rdata", l),
            lrd[l*W +: W], pend_d[l]);
      nv[l] = rst_n && lv[l] && !es;
      nd[l] = ref_mem[a];
    end
    @(posedge clk);
    for (int l = 0; l < L; l++) begin
      pend_v[l] = nv[l];
      pend_d[l] = nd[l];
    end
    if (fv) ref_mem[fa] = int'(fd);
    if (!rst_n || start) foreach (ref_full[i]) ref_full[i] = 1'b0;
    else if (fv && (fa % CH == CH - 1)) ref_full[fa / CH] = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_load(int lane, bit v, int a);
    lv[lane] = v;
    la[lane*AW +: AW] = AW'(a);
  endtask

  task automatic set_fill(bit v, int a, int d);
    fv = v; fa = AW'(a); fd = W'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 0;
    @(negedge clk);
    // R1: during reset with loads pending everything stalls
    set_load(0, 1, 0); set_load(1, 1, 100);
    repeat (3) step("R1");
    rst_n = 1'b1;
    step("R1");
    // R2: fill chunk 0 words 0..6, lane 0 waits on word 3
    set_load(1, 0, 0);
    set_load(0, 1, 3);
    for (int i = 0; i < CH - 1; i++) begin
      set_fill(1, i, 32'hA000 + i);
      step("R2");
    end
    // R5: last word fill under a waiting load
    set_fill(1, CH - 1, 32'hA000 + CH - 1);
    step("R5");
    set_fill(0, 0, 0);
    step("R5");
    // R3: data return
    set_load(0, 1, 7);
    step("R3");
    set_load(0, 0, 0);
    step("R3");
    // R6: lane 1 on empty chunk 5, lane 0 on full chunk 0
    set_load(0, 1, 2); set_load(1, 1, 5 * CH + 1);
    repeat (3) step("R6");
    // R8: chunk boundary between chunk 1 and 2
    set_load(0, 0, 0); set_load(1, 0, 0);
    for (int i = CH; i < 2 * CH; i++) begin
      set_fill(1, i, 32'hB000 + i);
      step("R8");
    end
    set_fill(0, 0, 0);
    set_load(0, 1, 2 * CH - 1); set_load(1, 1, 2 * CH);
    repeat (2) step("R8");
    // R7: start with a same-cycle last-word fill of chunk 2
    set_load(0, 0, 0); set_load(1, 0, 0);
    for (int i = 2 * CH; i < 3 * CH - 1; i++) begin
      set_fill(1, i, 32'hC000 + i);
      step("R7");
    end
    set_fill(1, 3 * CH - 1, 32'hC0FF);
    start = 1'b1;
    step("R7");
    start = 1'b0; set_fill(0, 0, 0);
    set_load(0, 1, 0); set_load(1, 1, 3 * CH - 1);
    repeat (2) step("R7");
    // R3, R4, R6, R7: random mix against the model
    set_load(0, 0, 0); set_load(1, 0, 0);
    begin
      int ptr = 0;
      for (int c = 0; c < 3000; c++) begin
        start = ($urandom_range(0, 99) == 0);
        if ($urandom_range(0, 3) != 0) begin
          set_fill(1, ptr, $urandom);
          ptr = (ptr + 1) % 160;
        end else set_fill(0, 0, 0);
        for (int l = 0; l < L; l++)
          set_load(l, $urandom_range(0, 1), $urandom_range(0, 191));
        step("R3");
      end
    end
    start = 1'b0; set_fill(0, 0, 0); set_load(0, 0, 0); set_load(1, 0, 0);
    step("R4");
    // R8: double-buffer instance, two half-buffer chunks
    for (int i = 0; i < 32; i++) begin
      d_fv = 1'b1; d_fa = 6'(i); d_fd = W'(32'hD00 + i);
      @(negedge clk);
    end
    d_fv = 1'b0;
    d_lv = 1'b1; d_la = 6'd5;
    #1;
    chk(d_stall == 1'b0, "R8", "half0 stall", d_stall, 0);
    @(negedge clk);
    chk(d_rv == 1'b1, "R8", "half0 rvalid", d_rv, 1);
    chk(d_rd == W'(32'hD05), "R8", "half0 rdata", d_rd, 32'hD05);
    d_la = 6'd40;
    #1;
    chk(d_stall == 1'b1, "R8", "half1 stall", d_stall, 1);
    @(negedge clk);
    chk(d_rv == 1'b0, "R8", "half1 rvalid", d_rv, 0);
    d_lv = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule